// File: doc/BRIEF.md
# Presettable Timer / Event Counter

This block is an 8-bit up-counter that can be preset and read in parallel. It runs in one of two modes. In timer mode it advances on a one-cycle tick from an external prescaler. In event mode it advances on each high-to-low transition of an asynchronous count pin. That pin is first synchronized through two flops and then passed through a falling-edge detector. Three commands control it: start as timer, start as event counter, and stop.

When the count steps from FF to 00 the block sets a sticky overflow flag and raises a one-cycle interrupt-request pulse. The interrupt request goes to arbitration logic outside this block. Software reads the flag with a test strobe, and that strobe also clears it.

Reset stops the counter and clears the flag, but it leaves the count value as it was. If software preloads FF in event mode, the next falling edge on the pin raises an interrupt request, so the pin serves as an additional interrupt input.

Top module: `tc_timer_counter`

## Requirements
- R1: With `load_i` high at a rising edge, `count_o` shows `load_val_i` from that edge onward. `count_o` always shows the current count.
- R2: Reset (`rst_n` low) stops the counter and clears the flag and the interrupt request. The count value keeps whatever it held before reset.
- R3: `cmd_i` is decoded as 2'b00 hold, 2'b01 start timer, 2'b10 start event counting, 2'b11 stop. A command takes effect at the edge where it is sampled. The counter advances only from the following cycle, and a stop still lets an increment in that same cycle complete. While stopped, neither the tick nor the pin changes the count.
- R4: In timer mode the count rises by one at each edge where `tick_i` is high. The pin is ignored in this mode.
- R5: In event mode, a high-to-low change of `evt_pin_i` that is set up before rising edge k raises the count at edge k+2. `tick_i` is ignored in this mode.
- R6: An increment from FF gives 00, and counting continues from there.
- R7: The increment from FF to 00 sets `flag_o`. It also drives `irq_o` high for exactly the one cycle that follows that edge.
- R8: `flag_test_i` high at an edge clears the flag. If an overflow happens at the same edge, the flag stays set.
- R9: When a load and an increment fall on the same edge, the loaded value wins and no overflow occurs.
- R10: If the counter is preloaded with FF in event mode, one falling edge on the pin gives count 00, sets the flag and produces one `irq_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle prescaler tick for timer mode |
| evt_pin_i | input | 1 | Asynchronous external count pin |
| load_i | input | 1 | Parallel load strobe |
| load_val_i | input | 8 | Value to load |
| cmd_i | input | 2 | Mode command (hold/timer/event/stop) |
| flag_test_i | input | 1 | Flag test strobe; clears the flag |
| count_o | output | 8 | Current count |
| flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | One-cycle overflow interrupt request |

## Verification
Results appear at different latencies:
- Loads, timer increments, commands, flag changes and the interrupt pulse appear one edge after the inputs are sampled.
- An event-mode increment appears at the third edge after the pin falls, because of the synchronizer and the edge detector.

The bench drives inputs on the falling clock edge and samples on the next falling edge. One table step therefore covers exactly one rising edge. For pin events it checks the count both at the second edge, where it must still be unchanged, and at the third edge, where it must have advanced. In this way a latency that is off by one cycle in either direction is caught.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        TC_CMD_HOLD  = 2'b00,
        TC_CMD_TIMER = 2'b01,
        TC_CMD_EVENT = 2'b10,
        TC_CMD_STOP  = 2'b11
    } tc_cmd_e;

    typedef enum logic [1:0] {
        TC_MODE_IDLE  = 2'b00,
        TC_MODE_TIMER = 2'b01,
        TC_MODE_EVENT = 2'b10
    } tc_mode_e;

    typedef struct packed {
        logic flag;
        logic irq;
    } tc_ovf_state_t;
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    localparam int CHAIN = STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[CHAIN-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    assign fall_o = st_q.chain[CHAIN-1] & ~st_q.chain[CHAIN-2];
endmodule

// File: rtl/tc_mode_ctrl.sv
module tc_mode_ctrl
    import tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_i,
    output tc_mode_e   mode_o
);
    tc_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        unique case (tc_cmd_e'(cmd_i))
            TC_CMD_TIMER: mode_d = TC_MODE_TIMER;
            TC_CMD_EVENT: mode_d = TC_MODE_EVENT;
            TC_CMD_STOP:  mode_d = TC_MODE_IDLE;
            default:      mode_d = mode_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= TC_MODE_IDLE;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        wrap_o  = 1'b0;
        if (load_i) begin
            count_d = load_val_i;
        end else if (inc_i) begin
            count_d = count_q + W'(1);
            wrap_o  = (count_q == MAXV);
        end
    end

    // Count register deliberately has no reset: reset keeps the value.
    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    assign count_o = count_q;
endmodule

// File: rtl/tc_ovf_flag.sv
module tc_ovf_flag
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic test_i,
    output logic flag_o,
    output logic irq_o
);
    tc_ovf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.irq = wrap_i;
        if (wrap_i)      st_d.flag = 1'b1;
        else if (test_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b0, irq: 1'b0};
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/tc_timer_counter.sv
module tc_timer_counter
    import tc_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         evt_pin_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [1:0]   cmd_i,
    input  logic         flag_test_i,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         irq_o
);
    tc_mode_e mode;
    logic     pin_fall;
    logic     inc;
    logic     wrap;

    tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (evt_pin_i),
        .fall_o (pin_fall)
    );

    tc_mode_ctrl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .mode_o (mode)
    );

    always_comb begin
        unique case (mode)
            TC_MODE_TIMER: inc = tick_i;
            TC_MODE_EVENT: inc = pin_fall;
            default:       inc = 1'b0;
        endcase
    end

    tc_count_core #(.W(W)) u_core (
        .clk        (clk),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .inc_i      (inc),
        .count_o    (count_o),
        .wrap_o     (wrap)
    );

    tc_ovf_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_i (wrap),
        .test_i (flag_test_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/tc_timer_counter_chk.sv
module tc_timer_counter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_i,
    input logic         load_i,
    input logic [W-1:0] load_val_i,
    input logic         flag_test_i,
    input logic [W-1:0] count_o,
    input logic         flag_o,
    input logic         irq_o,
    input logic [1:0]   mode
);
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    a_r6_irq_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_o == '0));

    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i)));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !load_i) |=> $stable(count_o));

    a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && tick_i && !load_i) |=> (count_o == $past(count_o) + W'(1)));

    a_r8_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flag_test_i |=> (!flag_o || irq_o));
endmodule

bind tc_timer_counter tc_timer_counter_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .flag_test_i (flag_test_i),
    .count_o     (count_o),
    .flag_o      (flag_o),
    .irq_o       (irq_o),
    .mode        (mode)
);

// File: tb/tc_timer_counter_bench.sv
module tc_timer_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       evt_pin_i = 1'b1;
    logic       load_i = 1'b0;
    logic [7:0] load_val_i = '0;
    logic [1:0] cmd_i = 2'b00;
    logic       flag_test_i = 1'b0;
    logic [7:0] count_o;
    logic       flag_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tc_timer_counter u_tc_timer_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .evt_pin_i(evt_pin_i),
        .load_i(load_i), .load_val_i(load_val_i), .cmd_i(cmd_i),
        .flag_test_i(flag_test_i), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    // {load, data[8], cmd[2], tick, test, exp_count[8], exp_flag, exp_irq}
    localparam int NV = 14;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 8'hFE, 2'b00, 1'b0, 1'b0, 8'hFE, 1'b0, 1'b0}, // R1 load
        {1'b0, 8'h00, 2'b01, 1'b1, 1'b0, 8'hFE, 1'b0, 1'b0}, // R3 start, no step yet
        {1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0}, // R4
        {1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0}, // R4 no tick
        {1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1}, // R6 R7 wrap
        {1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0}, // R6 R7
        {1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0}, // R8 clear
        {1'b1, 8'h10, 2'b00, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0}, // R9 load wins
        {1'b0, 8'h00, 2'b11, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0}, // R3 stop lets step finish
        {1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0}, // R3 stopped
        {1'b1, 8'hFF, 2'b01, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0}, // R1
        {1'b0, 8'h00, 2'b00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1}, // R8 test+overflow
        {1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R7
        {1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}  // R8
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        check("R2 flag after reset", {7'b0, flag_o}, 8'h00);
        check("R2 irq after reset", {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {load_i, load_val_i, cmd_i, tick_i, flag_test_i} = VEC[i][22:10];
            step();
            check($sformatf("R1/R3/R4/R6-R9 vec%0d count", i), count_o, VEC[i][9:2]);
            check($sformatf("R7/R8 vec%0d flag", i), {7'b0, flag_o}, {7'b0, VEC[i][1]});
            check($sformatf("R7 vec%0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][0]});
        end
        {load_i, cmd_i, tick_i, flag_test_i} = '0;

        // R4: timer mode ignores the pin
        cmd_i = 2'b01; load_i = 1'b1; load_val_i = 8'h40; step();
        cmd_i = 2'b00; load_i = 1'b0;
        evt_pin_i = 1'b0; step(); step(); step();
        evt_pin_i = 1'b1; step(); step(); step();
        check("R4 pin ignored in timer mode", count_o, 8'h40);

        // R5: event mode, latency and tick ignored
        cmd_i = 2'b10; load_i = 1'b1; load_val_i = 8'h05; step();
        cmd_i = 2'b00; load_i = 1'b0; tick_i = 1'b1;
        step();
        check("R5 tick ignored in event mode", count_o, 8'h05);
        evt_pin_i = 1'b0;
        step(); step();
        check("R5 no step at second edge", count_o, 8'h05);
        step();
        check("R5 step at third edge", count_o, 8'h06);
        step(); step();
        check("R5 one step per fall", count_o, 8'h06);
        tick_i = 1'b0;
        evt_pin_i = 1'b1; step(); step(); step();
        check("R5 rising edge ignored", count_o, 8'h06);

        // R10: preload FF, one fall requests interrupt
        load_i = 1'b1; load_val_i = 8'hFF; step();
        load_i = 1'b0;
        evt_pin_i = 1'b0; step(); step(); step();
        check("R10 count wraps", count_o, 8'h00);
        check("R10 irq pulse", {7'b0, irq_o}, 8'h01);
        check("R10 flag set", {7'b0, flag_o}, 8'h01);
        step();
        check("R10 irq single cycle", {7'b0, irq_o}, 8'h00);
        evt_pin_i = 1'b1; step(); step(); step();

        // R2: reset keeps count, clears flag, stops counter
        load_i = 1'b1; load_val_i = 8'h3C; cmd_i = 2'b01; step();
        load_i = 1'b0; cmd_i = 2'b00;
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1;
        check("R2 count kept through reset", count_o, 8'h3C);
        check("R2 flag cleared by reset", {7'b0, flag_o}, 8'h00);
        tick_i = 1'b1; step(); step();
        check("R2 stopped after reset", count_o, 8'h3C);
        tick_i = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule